// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits behind the host write port of a parallel NOR-style flash device. It follows every host write cycle (address plus data word) and picks out the multi-write unlock sequences that select an operation. A three-write sequence selects a simple command. A six-write sequence, with a setup byte, a second unlock pair and a final byte, starts erase or sector protection changes. When a sequence completes, the block raises a one-cycle request carrying an operation code and the sector number taken from the final write. The program/erase engine and the status logic act on that request.

The block also keeps the read-source selection used by the device read mux. That source is the array, the identifier codes or the status register. It also produces the identifier word for the current word address. A busy input from the program/erase engine blocks every completed command except status read and abort.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After synchronous reset, `req_valid` is 0 and `rd_sel` is 2'b00 (array). Array reads therefore need no command first.
- R2: The unlock pair is data 8'hAA at address 15'h5555 followed by data 8'h55 at address 15'h2AAA. Only address bits 14:0 are compared, and data bits 15:8 are ignored for every command write.
- R3: A third write at address 15'h5555 selects a simple command, reported on `req_op`: F0h read array = 0, 90h identifier = 1, 70h read status = 2, 50h clear status = 3, A0h page program = 4, E0h abort = 9. 80h and 60h start the long sequences, and any other byte gives no request.
- R4: After 80h, a second unlock pair and a sixth write of 10h at 15'h5555 request chip erase (op 5). A sixth write of 30h at any address requests sector erase (op 6).
- R5: After 60h and a second unlock pair, a sixth write of 20h requests protect (op 7) and 40h requests unprotect (op 8). This holds only when address bits 19:15 are 5'b00000 or 5'b11111; any other sector gives no request.
- R6: A write that does not match the expected address and data for the current step returns the tracker to idle without a request. That write is not taken as a fresh first unlock.
- R7: Each accepted command gives `req_valid` high for exactly one cycle, in the cycle after the final write. `req_sector` then equals address bits 19:15 of that write.
- R8: If `busy` is high during the final write, only read status (op 2) and abort (op 9) are issued. Every other completed sequence, including read array, is dropped.
- R9: `rd_sel` changes on the clock edge that ends the request pulse. Read array selects 2'b00, identifier selects 2'b01, and read status, program, either erase, protect and unprotect select 2'b10. Clear status and abort leave it unchanged.
- R10: `id_data` gives 16'h00C2 when `rd_word_lsb` is 0 and 16'h00F6 when it is 1, one cycle after `rd_word_lsb` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle host write strobe |
| wr_addr | input | 20 | Host write address (bits 19:15 sector) |
| wr_data | input | 16 | Host write data; low byte decoded |
| busy | input | 1 | Program/erase engine active |
| rd_word_lsb | input | 1 | Word address bit 0 for identifier reads |
| req_valid | output | 1 | One-cycle request strobe |
| req_op | output | 4 | Requested operation code |
| req_sector | output | 5 | Sector from the final write |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_data | output | 16 | Identifier word |

## Verification
If the sequence tracker is stuck in the wrong step, the fault appears at `req_valid` one cycle after the next final write. Either a request is missing, or a request appears after only a partial sequence. A wrong kind flag between the erase and protect paths shows up as the wrong `req_op` on the sixth write. A faulty read-select register shows up on `rd_sel` one cycle after the request pulse, and it persists until the next mode-changing command.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_RD_ARRAY  = 4'd0,
    OP_RD_ID     = 4'd1,
    OP_RD_STATUS = 4'd2,
    OP_CLR_STAT  = 4'd3,
    OP_PROGRAM   = 4'd4,
    OP_CHIP_ERS  = 4'd5,
    OP_SECT_ERS  = 4'd6,
    OP_PROTECT   = 4'd7,
    OP_UNPROTECT = 4'd8,
    OP_ABORT     = 4'd9
  } fcd_op_e;

  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_ID     = 2'd1,
    SEL_STATUS = 2'd2
  } fcd_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_UNL1,
    ST_CMD,
    ST_EXT1,
    ST_EXT2,
    ST_EXT3
  } fcd_step_e;

  localparam logic [7:0] KEY_A      = 8'hAA;
  localparam logic [7:0] KEY_B      = 8'h55;
  localparam logic [7:0] CB_RESET   = 8'hF0;
  localparam logic [7:0] CB_ID      = 8'h90;
  localparam logic [7:0] CB_PROG    = 8'hA0;
  localparam logic [7:0] CB_ERS_SU  = 8'h80;
  localparam logic [7:0] CB_STATUS  = 8'h70;
  localparam logic [7:0] CB_CLEAR   = 8'h50;
  localparam logic [7:0] CB_PROT_SU = 8'h60;
  localparam logic [7:0] CB_ABORT   = 8'hE0;
  localparam logic [7:0] CB_CHIP    = 8'h10;
  localparam logic [7:0] CB_SECT    = 8'h30;
  localparam logic [7:0] CB_LOCK    = 8'h20;
  localparam logic [7:0] CB_UNLOCK  = 8'h40;
  localparam logic [7:0] CODE_MFR   = 8'hC2;
  localparam logic [7:0] CODE_DEV   = 8'hF6;

endpackage

// File: rtl/fcd_write_match.sv
module fcd_write_match #(
  parameter int MATCH_W = 15
) (
  input  logic [MATCH_W-1:0] low_addr,
  input  logic [7:0]         cmd_byte,
  output logic               at_magic_a,
  output logic               key_a_hit,
  output logic               key_b_hit
);
  import fcd_pkg::*;

  localparam logic [MATCH_W-1:0] MAGIC_A = MATCH_W'(15'h5555);
  localparam logic [MATCH_W-1:0] MAGIC_B = MATCH_W'(15'h2AAA);

  logic at_magic_b;

  always_comb begin
    at_magic_a = (low_addr == MAGIC_A);
    at_magic_b = (low_addr == MAGIC_B);
    key_a_hit  = at_magic_a && (cmd_byte == KEY_A);
    key_b_hit  = at_magic_b && (cmd_byte == KEY_B);
  end

endmodule

// File: rtl/fcd_seq_tracker.sv
module fcd_seq_tracker #(
  parameter int ADDR_W = 20,
  parameter int SECT_W = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [7:0]         cmd_byte,
  input  logic               busy,
  output logic               req_valid,
  output fcd_pkg::fcd_op_e   req_op,
  output logic [SECT_W-1:0]  req_sector
);
  import fcd_pkg::*;

  localparam int MATCH_W = ADDR_W - SECT_W;

  fcd_step_e         step, step_nxt;
  logic              kind_prot, kind_nxt;
  logic              hit, accept;
  fcd_op_e           hit_op;
  logic              at_magic_a, key_a_hit, key_b_hit;
  logic [SECT_W-1:0] sect;
  logic              edge_sect;

  assign sect      = wr_addr[ADDR_W-1:MATCH_W];
  assign edge_sect = (sect == '0) || (sect == '1);

  fcd_write_match #(.MATCH_W(MATCH_W)) u_match (
    .low_addr  (wr_addr[MATCH_W-1:0]),
    .cmd_byte  (cmd_byte),
    .at_magic_a(at_magic_a),
    .key_a_hit (key_a_hit),
    .key_b_hit (key_b_hit)
  );

  always_comb begin
    step_nxt = step;
    kind_nxt = kind_prot;
    hit      = 1'b0;
    hit_op   = OP_RD_ARRAY;
    if (wr_en) begin
      step_nxt = ST_IDLE;
      case (step)
        ST_IDLE: if (key_a_hit) step_nxt = ST_UNL1;
        ST_UNL1: if (key_b_hit) step_nxt = ST_CMD;
        ST_CMD: begin
          if (at_magic_a) begin
            case (cmd_byte)
              CB_RESET:   begin hit = 1'b1; hit_op = OP_RD_ARRAY;  end
              CB_ID:      begin hit = 1'b1; hit_op = OP_RD_ID;     end
              CB_STATUS:  begin hit = 1'b1; hit_op = OP_RD_STATUS; end
              CB_CLEAR:   begin hit = 1'b1; hit_op = OP_CLR_STAT;  end
              CB_PROG:    begin hit = 1'b1; hit_op = OP_PROGRAM;   end
              CB_ABORT:   begin hit = 1'b1; hit_op = OP_ABORT;     end
              CB_ERS_SU:  begin step_nxt = ST_EXT1; kind_nxt = 1'b0; end
              CB_PROT_SU: begin step_nxt = ST_EXT1; kind_nxt = 1'b1; end
              default: ;
            endcase
          end
        end
        ST_EXT1: if (key_a_hit) step_nxt = ST_EXT2;
        ST_EXT2: if (key_b_hit) step_nxt = ST_EXT3;
        ST_EXT3: begin
          if (!kind_prot) begin
            if (at_magic_a && cmd_byte == CB_CHIP) begin
              hit = 1'b1; hit_op = OP_CHIP_ERS;
            end else if (cmd_byte == CB_SECT) begin
              hit = 1'b1; hit_op = OP_SECT_ERS;
            end
          end else if (edge_sect) begin
            if (cmd_byte == CB_LOCK) begin
              hit = 1'b1; hit_op = OP_PROTECT;
            end else if (cmd_byte == CB_UNLOCK) begin
              hit = 1'b1; hit_op = OP_UNPROTECT;
            end
          end
        end
        default: step_nxt = ST_IDLE;
      endcase
    end
  end

  assign accept = hit && (!busy || hit_op == OP_RD_STATUS || hit_op == OP_ABORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      step       <= ST_IDLE;
      kind_prot  <= 1'b0;
      req_valid  <= 1'b0;
      req_op     <= OP_RD_ARRAY;
      req_sector <= '0;
    end else begin
      step      <= step_nxt;
      kind_prot <= kind_nxt;
      req_valid <= accept;
      if (accept) begin
        req_op     <= hit_op;
        req_sector <= sect;
      end
    end
  end

  // R7
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> !req_valid);

  // R7
  req_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> $past(wr_en));

  // R5
  prot_edge_sector_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == OP_PROTECT || req_op == OP_UNPROTECT))
      |-> (req_sector == '0 || req_sector == '1));

  // R8
  busy_filter_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && $past(busy)) |-> (req_op == OP_RD_STATUS || req_op == OP_ABORT));

endmodule

// File: rtl/fcd_read_path.sv
module fcd_read_path #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  fcd_pkg::fcd_op_e  req_op,
  input  logic              rd_word_lsb,
  output fcd_pkg::fcd_sel_e rd_sel,
  output logic [DATA_W-1:0] id_data
);
  import fcd_pkg::*;

  localparam int PAD_W = DATA_W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_sel <= SEL_ARRAY;
    end else if (req_valid) begin
      case (req_op)
        OP_RD_ARRAY:  rd_sel <= SEL_ARRAY;
        OP_RD_ID:     rd_sel <= SEL_ID;
        OP_RD_STATUS,
        OP_PROGRAM,
        OP_CHIP_ERS,
        OP_SECT_ERS,
        OP_PROTECT,
        OP_UNPROTECT: rd_sel <= SEL_STATUS;
        default:      rd_sel <= rd_sel;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) id_data <= '0;
    else     id_data <= {{PAD_W{1'b0}}, (rd_word_lsb ? CODE_DEV : CODE_MFR)};
  end

  // R9
  array_select_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == OP_RD_ARRAY) |=> rd_sel == SEL_ARRAY);

  // R9
  keep_select_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == OP_CLR_STAT || req_op == OP_ABORT)) |=> $stable(rd_sel));

  // R9
  engine_status_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && (req_op == OP_PROGRAM || req_op == OP_SECT_ERS || req_op == OP_CHIP_ERS))
      |=> rd_sel == SEL_STATUS);

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  parameter int SECT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  input  logic              rd_word_lsb,
  output logic              req_valid,
  output logic [3:0]        req_op,
  output logic [SECT_W-1:0] req_sector,
  output logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] id_data
);
  import fcd_pkg::*;

  fcd_op_e  op_q;
  fcd_sel_e sel_q;
  logic     unused_hi_byte;

  assign unused_hi_byte = ^wr_data[DATA_W-1:8];

  fcd_seq_tracker #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_track (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .cmd_byte  (wr_data[7:0]),
    .busy      (busy),
    .req_valid (req_valid),
    .req_op    (op_q),
    .req_sector(req_sector)
  );

  fcd_read_path #(.DATA_W(DATA_W)) u_rdp (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_op     (op_q),
    .rd_word_lsb(rd_word_lsb),
    .rd_sel     (sel_q),
    .id_data    (id_data)
  );

  assign req_op = op_q;
  assign rd_sel = sel_q;

endmodule

// File: tb/tb_flash_cmd_decoder.sv
`timescale 1ns/1ps
module tb_flash_cmd_decoder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic        rd_word_lsb = 1'b0;
  logic        req_valid;
  logic [3:0]  req_op;
  logic [4:0]  req_sector;
  logic [1:0]  rd_sel;
  logic [15:0] id_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_cmd_decoder dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .rd_word_lsb(rd_word_lsb), .req_valid(req_valid), .req_op(req_op),
    .req_sector(req_sector), .rd_sel(rd_sel), .id_data(id_data)
  );

  // row: busy | addr | data | exp_valid | exp_op | exp_sector
  localparam int NV = 63;
  localparam logic [46:0] VEC [NV] = '{
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0070,1'b1,4'd2,5'd0},   // R3 status
    {1'b0,20'hF5555,16'hFFAA,1'b0,4'd0,5'd0},   // R2 upper bits ignored
    {1'b0,20'h7AAAA,16'h1255,1'b0,4'd0,5'd0},
    {1'b0,20'hA5555,16'hAB50,1'b1,4'd3,5'd20},  // R3 clear, R7 sector
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0090,1'b1,4'd1,5'd0},   // R3 id
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00A0,1'b1,4'd4,5'd0},   // R3 program
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0080,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0010,1'b1,4'd5,5'd0},   // R4 chip erase
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0080,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h3A000,16'h0030,1'b1,4'd6,5'd7},   // R4 sector erase
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0060,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'hF8000,16'h0020,1'b1,4'd7,5'd31},  // R5 protect top
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0060,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h00000,16'h0040,1'b1,4'd8,5'd0},   // R5 unprotect bottom
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0060,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h18000,16'h0020,1'b0,4'd0,5'd0},   // R5 middle sector refused
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAB,16'h0055,1'b0,4'd0,5'd0},   // R6 bad address
    {1'b0,20'h05555,16'h0070,1'b0,4'd0,5'd0},   // R6 back at idle
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00E0,1'b1,4'd9,5'd0},   // R3 abort
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b1,20'h05555,16'h00F0,1'b0,4'd0,5'd0},   // R8 reset while busy
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b1,20'h05555,16'h0070,1'b1,4'd2,5'd0},   // R8 status while busy
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b1,20'h05555,16'h00E0,1'b1,4'd9,5'd0},   // R8 abort while busy
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h0033,1'b0,4'd0,5'd0},   // R3 unknown byte
    {1'b0,20'h05555,16'h00AA,1'b0,4'd0,5'd0},
    {1'b0,20'h02AAA,16'h0055,1'b0,4'd0,5'd0},
    {1'b0,20'h05555,16'h00F0,1'b1,4'd0,5'd0}    // R3 read array
  };

  task automatic wr(input logic [19:0] a, input logic [15:0] d, input logic b);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; busy = b;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  task automatic cmd3(input logic [7:0] c, input logic b);
    wr(20'h05555, 16'h00AA, 1'b0);
    wr(20'h02AAA, 16'h0055, 1'b0);
    wr(20'h05555, {8'h00, c}, b);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R1 req_valid after reset", {15'd0, req_valid}, 16'd0);
    chk("R1 rd_sel after reset", {14'd0, rd_sel}, 16'd0);

    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      v = VEC[i];
      wr(v[45:26], v[25:10], v[46]);
      n_chk++;
      if (req_valid !== v[9] ||
          (v[9] && (req_op !== v[8:5] || req_sector !== v[4:0]))) begin
        n_bad++;
        $display("FAIL R2/R3/R4/R5/R6/R7/R8 row %0d actual v=%b op=%0d sec=%0d expected v=%b op=%0d sec=%0d",
                 i, req_valid, req_op, req_sector, v[9], v[8:5], v[4:0]);
      end
    end
    @(negedge clk);
    chk("R9 array after read array", {14'd0, rd_sel}, 16'd0);

    cmd3(8'h90, 1'b0);
    chk("R9 identifier select", {14'd0, rd_sel}, 16'd1);
    rd_word_lsb = 1'b0;
    @(negedge clk);
    chk("R10 manufacturer code", id_data, 16'h00C2);
    rd_word_lsb = 1'b1;
    @(negedge clk);
    chk("R10 device code", id_data, 16'h00F6);

    cmd3(8'h50, 1'b0);
    chk("R9 clear status keeps select", {14'd0, rd_sel}, 16'd1);
    cmd3(8'hA0, 1'b0);
    chk("R9 program selects status", {14'd0, rd_sel}, 16'd2);
    cmd3(8'hF0, 1'b1);
    chk("R8 busy read array ignored", {14'd0, rd_sel}, 16'd2);
    cmd3(8'hF0, 1'b0);
    chk("R9 read array returns", {14'd0, rd_sel}, 16'd0);

    rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 rd_sel after second reset", {14'd0, rd_sel}, 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule